// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit resolves control transfers for a 32-bit core with one architectural delay slot. It receives an instruction word with its address and the two source operand values. It decides whether the instruction redirects the fetch stream and computes where it goes. It also reports whether the return address must be written to the link register r31, and whether the delay-slot instruction must be squashed. All results are registered and appear on the clock edge after the instruction is presented with `insn_vld` high.

The unit handles the two-operand equality compares, the single-operand sign and zero tests, and the register-immediate group selected by a sub-opcode field. It also handles absolute jumps with and without link. The "likely" forms squash the delay slot when their condition fails. The linking forms of the register-immediate group write the return address whether or not they branch. A sub-opcode that names no defined operation raises an undefined-instruction flag instead of a result. Any other primary opcode leaves every flag low.

Top module: `branch_resolve_unit`

## Requirements
- R1: For a conditional branch the target is the instruction address plus 4 plus the sign-extended low 16 bits of the instruction shifted left by 2, wrapping modulo 2^32.
- R2: For primary opcodes 2 (jump) and 3 (jump with link), `taken` is 1 and the target is PC[31:28] followed by instruction bits 25:0 and two zero bits.
- R3: Opcodes 4 and 20 branch when the two operands are equal. Opcodes 5 and 21 branch when they differ.
- R4: Opcodes 6 and 22 branch when the first operand has bit 31 set or is zero. Opcodes 7 and 23 branch when bit 31 is clear and the value is nonzero.
- R5: Opcode 1 selects the register-immediate group with sub-opcode in bits 20:16. A sub-opcode with bit 0 clear branches when bit 31 of the first operand is set, and one with bit 0 set branches when it is clear.
- R6: `link_we` is 1 for opcode 3 and for valid register-immediate sub-opcodes with bit 4 set, whatever the condition. `link_value` then equals PC + 8, wrapping. `link_we` is 0 for every other instruction.
- R7: `annul_slot` is 1 only for a likely form whose condition fails. The likely forms are opcodes 20 to 23 and register-immediate sub-opcodes with bit 1 set. Plain branches and jumps never raise it, and it is never 1 together with `taken`.
- R8: Only register-immediate sub-opcodes 0-3 and 16-19 are defined, the ones with bits 3:2 equal to zero. Any other sub-opcode sets `undef_trap` and leaves `taken`, `link_we` and `annul_slot` at 0.
- R9: Opcodes outside 1-7 and 20-23 give no flags. A cycle with `insn_vld` low clears every flag on the next edge.
- R10: Results appear exactly one clock edge after the inputs are sampled. While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| insn_vld | input | 1 | Instruction on `insn` is to be resolved this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| taken | output | 1 | Control transfer happens |
| target_pc | output | 32 | Destination address, meaningful when `taken` is 1 |
| link_we | output | 1 | Write `link_value` to r31 |
| link_value | output | 32 | Return address PC + 8 |
| annul_slot | output | 1 | Squash the delay-slot instruction |
| undef_trap | output | 1 | Undefined register-immediate sub-opcode |

## Verification
The bench aims at the edges of the sign and zero tests: zero, the most negative value, all ones and the largest positive value. A design that treated zero as positive, or compared the operands as unsigned, would branch the wrong way there. Linking register-immediate forms are driven with failing conditions, which catches a design that writes r31 only when it branches. Likely forms are driven both ways, which catches a squash raised on the taken path or on a plain branch. An offset of 0x8000 and addresses near 2^32 expose a missing sign extension, a missing wrap, or a jump segment taken from the wrong address bits. The bench also checks that undefined sub-opcodes trap without a side effect, and that results keep their one-edge latency.

// File: rtl/bju_pkg.sv
package bju_pkg;

  // primary opcodes that the unit reacts to
  localparam logic [5:0] OPC_REGIMM = 6'd1;
  localparam logic [5:0] OPC_JUMP   = 6'd2;
  localparam logic [5:0] OPC_JLINK  = 6'd3;

  // condition the resolved instruction tests
  typedef enum logic [2:0] {
    CND_NEVER,
    CND_EQ,
    CND_NE,
    CND_LEZ,
    CND_GTZ,
    CND_LTZ,
    CND_GEZ,
    CND_ALWAYS
  } cond_e;

  // decoded control for one instruction
  typedef struct packed {
    logic  xfer;      // instruction may redirect fetch
    logic  absolute;  // target from index field, not offset
    logic  likely;    // squash slot when condition fails
    logic  link;      // write return address
    logic  bad;       // undefined sub-opcode
    cond_e cond;
  } ctl_t;

endpackage

// File: rtl/bju_decode.sv
module bju_decode
  import bju_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] subop,
  output ctl_t       ctl
);

  logic cmp_group;

  // opcodes 4..7 and 20..23 share the same low-bit layout
  assign cmp_group = (opcode[5:2] == 4'b0001) || (opcode[5:2] == 4'b0101);

  always_comb begin
    ctl = '{xfer: 1'b0, absolute: 1'b0, likely: 1'b0, link: 1'b0,
            bad: 1'b0, cond: CND_NEVER};
    if (opcode == OPC_REGIMM) begin
      if (subop[3:2] == 2'b00) begin
        ctl.xfer   = 1'b1;
        ctl.likely = subop[1];
        ctl.link   = subop[4];
        ctl.cond   = subop[0] ? CND_GEZ : CND_LTZ;
      end else begin
        ctl.bad    = 1'b1;
      end
    end else if (opcode == OPC_JUMP || opcode == OPC_JLINK) begin
      ctl.xfer     = 1'b1;
      ctl.absolute = 1'b1;
      ctl.link     = opcode[0];
      ctl.cond     = CND_ALWAYS;
    end else if (cmp_group) begin
      ctl.xfer   = 1'b1;
      ctl.likely = opcode[4];
      unique case (opcode[1:0])
        2'd0:    ctl.cond = CND_EQ;
        2'd1:    ctl.cond = CND_NE;
        2'd2:    ctl.cond = CND_LEZ;
        default: ctl.cond = CND_GTZ;
      endcase
    end
  end

endmodule

// File: rtl/bju_cond.sv
module bju_cond
  import bju_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cond_e            cond,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  output logic             hold
);

  localparam int SIGN = XLEN - 1;

  logic neg, zero, same;

  assign neg  = opa[SIGN];
  assign zero = (opa == '0);
  assign same = (opa == opb);

  always_comb begin
    unique case (cond)
      CND_EQ:     hold = same;
      CND_NE:     hold = !same;
      CND_LEZ:    hold = neg || zero;
      CND_GTZ:    hold = !neg && !zero;
      CND_LTZ:    hold = neg;
      CND_GEZ:    hold = !neg;
      CND_ALWAYS: hold = 1'b1;
      default:    hold = 1'b0;
    endcase
  end

endmodule

// File: rtl/bju_target.sv
module bju_target #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IDX_W-1:0] idx_field,
  input  logic             absolute,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  link_addr
);

  localparam int WSH   = 2;                   // word alignment shift
  localparam int SEG_W = XLEN - IDX_W - WSH;  // address bits kept by a jump
  localparam int EXT_W = XLEN - OFF_W - WSH;  // sign-extension bits

  logic [OFF_W-1:0] off;
  logic [XLEN-1:0]  off_ext;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  rel_tgt;
  logic [XLEN-1:0]  abs_tgt;

  assign off     = idx_field[OFF_W-1:0];
  assign off_ext = {{EXT_W{off[OFF_W-1]}}, off, {WSH{1'b0}}};
  assign seq_pc  = pc + XLEN'(4);
  assign rel_tgt = seq_pc + off_ext;

  generate
    if (SEG_W > 0) begin : g_seg
      assign abs_tgt = {pc[XLEN-1 -: SEG_W], idx_field, {WSH{1'b0}}};
    end else begin : g_noseg
      assign abs_tgt = XLEN'({idx_field, {WSH{1'b0}}});
    end
  endgenerate

  assign target    = absolute ? abs_tgt : rel_tgt;
  assign link_addr = pc + XLEN'(8);

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bju_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_vld,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            taken,
  output logic [XLEN-1:0] target_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_value,
  output logic            annul_slot,
  output logic            undef_trap
);

  ctl_t            ctl;
  logic            cond_ok;
  logic [XLEN-1:0] tgt_c;
  logic [XLEN-1:0] link_c;

  logic            taken_d, link_we_d, annul_d, trap_d;
  logic            addr_en;

  bju_decode u_dec (
    .opcode (insn[31:26]),
    .subop  (insn[20:16]),
    .ctl    (ctl)
  );

  bju_cond #(.XLEN(XLEN)) u_cond (
    .cond (ctl.cond),
    .opa  (rs_val),
    .opb  (rt_val),
    .hold (cond_ok)
  );

  bju_target #(.XLEN(XLEN)) u_tgt (
    .pc        (pc),
    .idx_field (insn[25:0]),
    .absolute  (ctl.absolute),
    .target    (tgt_c),
    .link_addr (link_c)
  );

  // next-state
  always_comb begin
    taken_d   = insn_vld && ctl.xfer && cond_ok;
    link_we_d = insn_vld && ctl.link;
    annul_d   = insn_vld && ctl.xfer && ctl.likely && !cond_ok;
    trap_d    = insn_vld && ctl.bad;
    addr_en   = insn_vld;
  end

  // flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken      <= 1'b0;
      link_we    <= 1'b0;
      annul_slot <= 1'b0;
      undef_trap <= 1'b0;
    end else begin
      taken      <= taken_d;
      link_we    <= link_we_d;
      annul_slot <= annul_d;
      undef_trap <= trap_d;
    end
  end

  // address registers, enabled only for presented instructions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_pc  <= '0;
      link_value <= '0;
    end else if (addr_en) begin
      target_pc  <= tgt_c;
      link_value <= link_c;
    end
  end

endmodule

// File: rtl/bju_checker.sv
module bju_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_vld,
  input logic [31:0]     insn,
  input logic [XLEN-1:0] pc,
  input logic            taken,
  input logic            link_we,
  input logic [XLEN-1:0] link_value,
  input logic            annul_slot,
  input logic            undef_trap
);

  a_r7_annul_excludes_taken: assert property (@(posedge clk) disable iff (!rst_n)
    annul_slot |-> !taken);

  a_r8_trap_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap |-> (!taken && !link_we && !annul_slot));

  a_r8_bad_subop_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && insn[31:26] == 6'd1 && insn[19:18] != 2'b00) |=> undef_trap);

  a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> (!taken && !link_we && !annul_slot && !undef_trap));

  a_r2_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && insn[31:27] == 5'b00001) |=> (taken && !annul_slot));

  a_r6_link_address: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && insn[31:26] == 6'd3) |=> (link_we && link_value == $past(pc) + XLEN'(8)));

endmodule

bind branch_resolve_unit bju_checker #(.XLEN(XLEN)) u_bju_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_vld   (insn_vld),
  .insn       (insn),
  .pc         (pc),
  .taken      (taken),
  .link_we    (link_we),
  .link_value (link_value),
  .annul_slot (annul_slot),
  .undef_trap (undef_trap)
);

// File: tb/tb_branch_resolve_unit.sv
`timescale 1ns/1ps
module tb_branch_resolve_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_vld;
  logic [31:0] insn, pc, rs_val, rt_val;
  logic        taken, link_we, annul_slot, undef_trap;
  logic [31:0] target_pc, link_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  branch_resolve_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn(insn), .pc(pc),
    .rs_val(rs_val), .rt_val(rt_val), .taken(taken), .target_pc(target_pc),
    .link_we(link_we), .link_value(link_value), .annul_slot(annul_slot),
    .undef_trap(undef_trap)
  );

  localparam logic [31:0] P = 32'h0040_1000;
  localparam int NV = 29;
  // {insn, pc, rs, rt, taken, annul, link_we, trap, target}
  localparam logic [163:0] VEC [NV] = '{
    {32'h10000010, P, 32'd5, 32'd5, 4'b1000, 32'h00401044},  // beq equal
    {32'h10000010, P, 32'd5, 32'd6, 4'b0000, 32'h0},         // beq differ
    {32'h1400FFFF, P, 32'd1, 32'd2, 4'b1000, 32'h00401000},  // bne back one
    {32'h10008000, P, 32'd9, 32'd9, 4'b1000, 32'h003E1004},  // most negative offset
    {32'h50000008, P, 32'd7, 32'd7, 4'b1000, 32'h00401024},  // beq likely taken
    {32'h50000008, P, 32'd1, 32'd2, 4'b0100, 32'h0},         // beq likely fails
    {32'h54000004, P, 32'd3, 32'd3, 4'b0100, 32'h0},         // bne likely fails
    {32'h18000004, P, 32'd0, 32'd0, 4'b1000, 32'h00401014},  // lez zero
    {32'h18000004, P, 32'h80000000, 32'd0, 4'b1000, 32'h00401014},
    {32'h18000004, P, 32'd1, 32'd0, 4'b0000, 32'h0},
    {32'h1C000004, P, 32'd1, 32'd0, 4'b1000, 32'h00401014},  // gtz one
    {32'h1C000004, P, 32'd0, 32'd0, 4'b0000, 32'h0},         // gtz zero
    {32'h1C000004, P, 32'hFFFFFFFF, 32'd0, 4'b0000, 32'h0},
    {32'h5C000004, P, 32'd0, 32'd0, 4'b0100, 32'h0},         // gtz likely fails
    {32'h5C000004, P, 32'h7FFFFFFF, 32'd0, 4'b1000, 32'h00401014},
    {32'h58000004, P, 32'd5, 32'd0, 4'b0100, 32'h0},         // lez likely fails
    {32'h04000004, P, 32'h80000000, 32'd0, 4'b1000, 32'h00401014}, // ltz
    {32'h04010004, P, 32'd0, 32'd0, 4'b1000, 32'h00401014},  // gez zero
    {32'h04020004, P, 32'd1, 32'd0, 4'b0100, 32'h0},         // ltz likely fails
    {32'h04030004, P, 32'hFFFFFFFF, 32'd0, 4'b0100, 32'h0},  // gez likely fails
    {32'h04100004, P, 32'd1, 32'd0, 4'b0010, 32'h0},         // ltz link, fails
    {32'h04110004, P, 32'd3, 32'd0, 4'b1010, 32'h00401014},  // gez link taken
    {32'h04120004, P, 32'd0, 32'd0, 4'b0110, 32'h0},         // ltz link likely fails
    {32'h04130004, P, 32'h80000000, 32'd0, 4'b0110, 32'h0},  // gez link likely fails
    {32'h04040004, P, 32'h80000000, 32'd0, 4'b0001, 32'h0},  // undefined sub 4
    {32'h08100040, 32'hA0001000, 32'd0, 32'd0, 4'b1000, 32'hA0400100}, // jump
    {32'h0C000010, P, 32'd0, 32'd0, 4'b1010, 32'h00000040},  // jump link
    {32'h20000004, P, 32'd0, 32'd0, 4'b0000, 32'h0},         // not a transfer
    {32'h04080004, P, 32'd0, 32'd0, 4'b0001, 32'h0}          // undefined sub 8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    insn_vld = v; insn = i; pc = p; rs_val = a; rt_val = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_vld = 1'b1; insn = 32'h10000010; pc = P; rs_val = 0; rt_val = 0;
    repeat (3) @(negedge clk);
    // R10: flags held low in reset despite a taken branch at the inputs
    chk("R10 reset taken", {31'd0, taken}, 32'd0);
    chk("R10 reset link_we", {31'd0, link_we}, 32'd0);
    chk("R10 reset annul", {31'd0, annul_slot}, 32'd0);
    chk("R10 reset trap", {31'd0, undef_trap}, 32'd0);
    insn_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [163:0] v;
      v = VEC[k];
      apply(1'b1, v[163:132], v[131:100], v[99:68], v[67:36]);
      chk($sformatf("R3/R4/R5 taken vec%0d", k), {31'd0, taken}, {31'd0, v[35]});
      chk($sformatf("R7 annul vec%0d", k), {31'd0, annul_slot}, {31'd0, v[34]});
      chk($sformatf("R6 link_we vec%0d", k), {31'd0, link_we}, {31'd0, v[33]});
      chk($sformatf("R8 trap vec%0d", k), {31'd0, undef_trap}, {31'd0, v[32]});
      if (v[35]) begin
        if (v[163:159] == 5'b00001)
          chk($sformatf("R2 jump target vec%0d", k), target_pc, v[31:0]);
        else
          chk($sformatf("R1 branch target vec%0d", k), target_pc, v[31:0]);
      end
      if (v[33])
        chk($sformatf("R6 link value vec%0d", k), link_value, v[131:100] + 32'd8);
    end

    // R9: idle cycle with a taken branch on the bus gives no flags
    apply(1'b0, 32'h10000010, P, 32'd4, 32'd4);
    chk("R9 idle taken", {31'd0, taken}, 32'd0);
    chk("R9 idle link", {31'd0, link_we}, 32'd0);
    // R10: drive a taken branch, outputs unchanged until the edge
    insn_vld = 1'b1; insn = 32'h10000010; pc = P; rs_val = 1; rt_val = 1;
    #1;
    chk("R10 no early result", {31'd0, taken}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 result after edge", {31'd0, taken}, 32'd1);
    // R6/R2 wrap near top of address space
    apply(1'b1, 32'h0C000010, 32'hFFFFFFF8, 32'd0, 32'd0);
    chk("R6 link wraps", link_value, 32'h00000000);
    chk("R2 jump segment high", target_pc, 32'hF0000040);
    // R1 wrap of relative target
    apply(1'b1, 32'h10000001, 32'hFFFFFFF8, 32'd2, 32'd2);
    chk("R1 target wraps", target_pc, 32'h00000000);
    // R9 unrelated opcode clears flags after a linking jump
    apply(1'b1, 32'h0C000010, P, 32'd0, 32'd0);
    apply(1'b1, 32'h8C000000, P, 32'd0, 32'd0);
    chk("R9 other opcode link", {31'd0, link_we}, 32'd0);
    chk("R9 other opcode taken", {31'd0, taken}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule